// File: doc/BRIEF.md
# Synchronous Burst SRAM Access Controller

This block is a cycle-level model of a single-ported synchronous burst SRAM. On each rising clock edge it samples three chip selects of mixed polarity, two address strobes, a burst-advance request, the address and the write controls. From these it decides whether the cycle starts a read, starts a write, continues a burst or deselects the part. It then drives per-lane write enables into a small storage array. Each word holds two 8-bit data lanes and one parity bit per lane.

A burst is opened by either strobe. The processor-side strobe always reads in its first cycle. The controller-side strobe reads or writes depending on the write controls in that same cycle. Later cycles with no strobe continue the burst: the write controls decide between read and write, and the advance request moves to the next address of a 2-bit wrapping sequence. The sequence is linear or interleaved, chosen when the burst opens. Read data comes out through a register. A bus-drive flag tells the pad ring when to drive the shared data bus. A sleep input freezes the whole block.

Top module: `sbsram_ctrl`

## Requirements
- R1: An access starts only when sel_a_n=0, sel_b=1 and sel_c_n=0 at the edge. A strobe with any select inactive ends the burst, writes nothing and leaves bus_drive low afterwards.
- R2: cpu_start_n is ignored while sel_a_n=1; with no burst open such a cycle changes nothing.
- R3: A burst opened by cpu_start_n performs a read in its first cycle whatever the write controls are. The next cycle, with no strobe and write controls active, writes wdata to the same address.
- R4: A burst opened by ctl_start_n (with cpu_start_n not taking it) reads if no lane write is requested in that cycle, and writes in that same cycle otherwise.
- R5: all_wr_n=0 writes both lanes, whatever lane_wr_n and lane_sel_n are.
- R6: With all_wr_n=1, lane i is written only when lane_wr_n=0 and lane_sel_n[i]=0. Lane 0 is wdata[7:0] plus wdata[16]; lane 1 is wdata[15:8] plus wdata[17].
- R7: rdata shows the word at the address read at the previous edge, and holds otherwise.
- R8: bus_drive is high only when out_en_n=0, sleep=0, the previous edge performed a read and no write is requested in the present cycle. out_en_n acts without a clock.
- R9: While sleep=1 all other inputs are ignored: no write, no change of burst state or rdata, and bus_drive low.
- R10: In a continuing cycle adv_n=0 moves to the next address of the burst, wrapping within the aligned group of four. The upper address bits are kept.
- R11: With lin_order=1 at burst start the k-th address is (base+k) mod 4; with lin_order=0 it is base XOR k, both in the two low address bits.
- R12: A continuing cycle with adv_n=1 accesses the current burst address again.
- R13: After reset no burst is open and bus_drive is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_a_n | input | 1 | Chip select, active low; also gates cpu_start_n |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| cpu_start_n | input | 1 | Processor-side address strobe, active low |
| ctl_start_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance request, active low |
| addr | input | AW | Word address |
| all_wr_n | input | 1 | Global write, active low |
| lane_wr_n | input | 1 | Lane write enable, active low |
| lane_sel_n | input | LANES | Per-lane write select, active low |
| lin_order | input | 1 | Burst order at burst start: 1 linear, 0 interleaved |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Freeze request, active high |
| wdata | input | W | Write word: lanes then parity bits |
| rdata | output | W | Registered read word |
| bus_drive | output | 1 | High when the data bus may be driven |

## Verification
A vector table first fills four words with global writes. It then reads them as a linear burst that wraps, repeats an address without advance, and opens a processor-strobe cycle with the global write held active, which must read. A lane-0 write follows, then a lane-1 write, a global write with every lane select off, and a strobe with lane selects but no lane enable, which must read. Each pattern separates one lane or override rule from the others. Directed tests cover an interleaved burst, a burst write that wraps, deselect through each non-gating select, the gated processor strobe, and the conditions on the bus-drive flag. A sleep window holds a write strobe to a different address; after wake-up the old burst address must still read its old data.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
  localparam int unsigned BURST_BITS = 2;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_CPU  = 2'd1,
    SRC_CTL  = 2'd2
  } start_src_e;

  function automatic logic [BURST_BITS-1:0] burst_seq(
    input logic [BURST_BITS-1:0] base,
    input logic [BURST_BITS-1:0] k,
    input logic                  linear
  );
    return linear ? (base + k) : (base ^ k);
  endfunction
endpackage

// File: rtl/sbsram_burst.sv
module sbsram_burst
  import sbsram_pkg::*;
#(
  parameter int unsigned BW = BURST_BITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  input  logic          load,
  input  logic          step,
  input  logic [BW-1:0] base,
  input  logic          linear,
  output logic [BW-1:0] cur,
  output logic [BW-1:0] nxt
);
  logic [BW-1:0] base_q, base_d;
  logic [BW-1:0] cnt_q, cnt_d;
  logic          lin_q, lin_d;

  always_comb begin
    base_d = base_q;
    cnt_d  = cnt_q;
    lin_d  = lin_q;
    if (load) begin
      base_d = base;
      cnt_d  = '0;
      lin_d  = linear;
    end else if (step) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
      lin_q  <= 1'b1;
    end else if (ce) begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
      lin_q  <= lin_d;
    end
  end

  assign cur = burst_seq(base_q, cnt_q, lin_q);
  assign nxt = burst_seq(base_q, cnt_q + 1'b1, lin_q);

  // R10: the count moves by one and wraps on every advance
  a_r10_step_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && step && !load) |=> (cnt_q == BW'($past(cnt_q) + 1'b1)));
endmodule

// File: rtl/sbsram_decode.sv
module sbsram_decode
  import sbsram_pkg::*;
#(
  parameter int unsigned LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep,
  input  logic             sel_a_n,
  input  logic             sel_b,
  input  logic             sel_c_n,
  input  logic             cpu_start_n,
  input  logic             ctl_start_n,
  input  logic             adv_n,
  input  logic             all_wr_n,
  input  logic             lane_wr_n,
  input  logic [LANES-1:0] lane_sel_n,
  output logic             load,
  output logic             step,
  output logic             rd_go,
  output logic             wr_go,
  output logic [LANES-1:0] lane_we
);
  logic             chip_sel;
  start_src_e       src;
  logic [LANES-1:0] lanes_req;
  logic             any_wr;
  logic             act_q, act_d;

  assign chip_sel = !sel_a_n && sel_b && !sel_c_n;

  always_comb begin
    if (!cpu_start_n && !sel_a_n) src = SRC_CPU;
    else if (!ctl_start_n)        src = SRC_CTL;
    else                          src = SRC_NONE;
  end

  always_comb begin
    for (int i = 0; i < int'(LANES); i++) begin
      lanes_req[i] = !all_wr_n || (!lane_wr_n && !lane_sel_n[i]);
    end
  end
  assign any_wr = |lanes_req;

  always_comb begin
    load    = 1'b0;
    step    = 1'b0;
    rd_go   = 1'b0;
    wr_go   = 1'b0;
    lane_we = '0;
    act_d   = act_q;
    if (!sleep) begin
      if (src != SRC_NONE) begin
        if (chip_sel) begin
          load  = 1'b1;
          act_d = 1'b1;
          if (src == SRC_CTL && any_wr) begin
            wr_go   = 1'b1;
            lane_we = lanes_req;
          end else begin
            rd_go = 1'b1;
          end
        end else begin
          act_d = 1'b0;
        end
      end else if (act_q) begin
        step = !adv_n;
        if (any_wr) begin
          wr_go   = 1'b1;
          lane_we = lanes_req;
        end else begin
          rd_go = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      act_q <= 1'b0;
    else if (!sleep) act_q <= act_d;
  end

  // R3: the processor strobe never writes in its opening cycle
  a_r3_cpu_opens_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !cpu_start_n && !sel_a_n) |-> (lane_we == '0));

  // R1: a strobe seen while deselected writes nothing and closes the burst
  a_r1_desel_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !chip_sel && (!ctl_start_n || (!cpu_start_n && !sel_a_n)))
      |=> !act_q);
endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned LANES = 2,
  parameter int unsigned LB    = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned W    = LANES * (LB + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic             re,
  input  logic [LANES-1:0] we,
  input  logic [AW-1:0]    addr,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     rdata
);
  for (genvar g = 0; g < int'(LANES); g++) begin : g_lane
    logic [LB:0] store [DEPTH];
    logic [LB:0] wr_word;
    logic [LB:0] rd_q;

    assign wr_word = {wdata[LANES*LB+g], wdata[g*LB +: LB]};

    always_ff @(posedge clk) begin
      if (ce && we[g]) store[addr] <= wr_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        rd_q <= '0;
      else if (ce && re) rd_q <= store[addr];
    end

    assign rdata[g*LB +: LB]  = rd_q[LB-1:0];
    assign rdata[LANES*LB+g]  = rd_q[LB];
  end

  // R7: read and write never coincide on the array
  a_r7_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(re && (we != '0)));
endmodule

// File: rtl/sbsram_ctrl.sv
module sbsram_ctrl
  import sbsram_pkg::*;
#(
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned LANES     = 2,
  parameter int unsigned LANE_BITS = 8,
  localparam int unsigned AW       = $clog2(DEPTH),
  localparam int unsigned BW       = BURST_BITS,
  localparam int unsigned W        = LANES * (LANE_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_a_n,
  input  logic             sel_b,
  input  logic             sel_c_n,
  input  logic             cpu_start_n,
  input  logic             ctl_start_n,
  input  logic             adv_n,
  input  logic [AW-1:0]    addr,
  input  logic             all_wr_n,
  input  logic             lane_wr_n,
  input  logic [LANES-1:0] lane_sel_n,
  input  logic             lin_order,
  input  logic             out_en_n,
  input  logic             sleep,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     rdata,
  output logic             bus_drive
);
  logic             ce;
  logic             load, step, rd_go, wr_go;
  logic [LANES-1:0] lane_we;
  logic [BW-1:0]    seq_cur, seq_nxt;
  logic [AW-BW-1:0] hi_q, hi_d;
  logic             rdv_q, rdv_d;
  logic [AW-1:0]    eff_addr;

  assign ce = !sleep;

  sbsram_decode #(.LANES(LANES)) u_decode (
    .clk         (clk),
    .rst_n       (rst_n),
    .sleep       (sleep),
    .sel_a_n     (sel_a_n),
    .sel_b       (sel_b),
    .sel_c_n     (sel_c_n),
    .cpu_start_n (cpu_start_n),
    .ctl_start_n (ctl_start_n),
    .adv_n       (adv_n),
    .all_wr_n    (all_wr_n),
    .lane_wr_n   (lane_wr_n),
    .lane_sel_n  (lane_sel_n),
    .load        (load),
    .step        (step),
    .rd_go       (rd_go),
    .wr_go       (wr_go),
    .lane_we     (lane_we)
  );

  sbsram_burst #(.BW(BW)) u_burst (
    .clk    (clk),
    .rst_n  (rst_n),
    .ce     (ce),
    .load   (load),
    .step   (step),
    .base   (addr[BW-1:0]),
    .linear (lin_order),
    .cur    (seq_cur),
    .nxt    (seq_nxt)
  );

  always_comb begin
    if (load)      eff_addr = addr;
    else if (step) eff_addr = {hi_q, seq_nxt};
    else           eff_addr = {hi_q, seq_cur};
  end

  always_comb begin
    hi_d  = load ? addr[AW-1:BW] : hi_q;
    rdv_d = rd_go;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      rdv_q <= 1'b0;
    end else if (ce) begin
      hi_q  <= hi_d;
      rdv_q <= rdv_d;
    end
  end

  sbsram_array #(
    .DEPTH (DEPTH),
    .LANES (LANES),
    .LB    (LANE_BITS)
  ) u_array (
    .clk   (clk),
    .rst_n (rst_n),
    .ce    (ce),
    .re    (rd_go),
    .we    (lane_we),
    .addr  (eff_addr),
    .wdata (wdata),
    .rdata (rdata)
  );

  assign bus_drive = ce && !out_en_n && rdv_q && !wr_go;

  // R8: the bus is never driven against a high output enable or in sleep
  a_r8_drive_needs_oe: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drive |-> (!out_en_n && !sleep));

  // R9: read data is frozen across a sleep cycle
  a_r9_sleep_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> $stable(rdata));

  // R5: a global write always reaches every lane
  a_r5_global_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && !all_wr_n) |-> (lane_we == '1));
endmodule

// File: tb/sim_sbsram_ctrl.sv
module sim_sbsram_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sel_a_n, sel_b, sel_c_n;
  logic        cpu_start_n, ctl_start_n, adv_n;
  logic [3:0]  addr;
  logic        all_wr_n, lane_wr_n;
  logic [1:0]  lane_sel_n;
  logic        lin_order, out_en_n, sleep;
  logic [17:0] wdata;
  logic [17:0] rdata;
  logic        bus_drive;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  sbsram_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .cpu_start_n(cpu_start_n), .ctl_start_n(ctl_start_n), .adv_n(adv_n), .addr(addr),
    .all_wr_n(all_wr_n), .lane_wr_n(lane_wr_n), .lane_sel_n(lane_sel_n),
    .lin_order(lin_order), .out_en_n(out_en_n), .sleep(sleep), .wdata(wdata),
    .rdata(rdata), .bus_drive(bus_drive)
  );

  // st: 0 none, 1 processor strobe, 2 controller strobe; ls: lane selects, 1 = selected
  typedef struct packed {
    logic [1:0]  st;
    logic        adv;
    logic        gw;
    logic        bwe;
    logic [1:0]  ls;
    logic [3:0]  ad;
    logic [17:0] wd;
    logic        chk;
    logic [17:0] ex;
    logic [3:0]  rq;
  } vec_t;

  localparam vec_t TBL [17] = '{
    '{2'd2, 1'b0, 1'b1, 1'b0, 2'b00, 4'd0, 18'h2A5A5, 1'b0, 18'h0,     4'd5},  // R5 fill
    '{2'd2, 1'b0, 1'b1, 1'b0, 2'b00, 4'd1, 18'h15A5A, 1'b0, 18'h0,     4'd5},
    '{2'd2, 1'b0, 1'b1, 1'b0, 2'b00, 4'd2, 18'h00F0F, 1'b0, 18'h0,     4'd5},
    '{2'd2, 1'b0, 1'b1, 1'b0, 2'b00, 4'd3, 18'h3C3C3, 1'b0, 18'h0,     4'd5},
    '{2'd2, 1'b0, 1'b0, 1'b0, 2'b00, 4'd1, 18'h0,     1'b1, 18'h15A5A, 4'd7},  // R7 R4 read
    '{2'd0, 1'b1, 1'b0, 1'b0, 2'b00, 4'd0, 18'h0,     1'b1, 18'h00F0F, 4'd10}, // R10 advance
    '{2'd0, 1'b1, 1'b0, 1'b0, 2'b00, 4'd0, 18'h0,     1'b1, 18'h3C3C3, 4'd11}, // R11 linear
    '{2'd0, 1'b1, 1'b0, 1'b0, 2'b00, 4'd0, 18'h0,     1'b1, 18'h2A5A5, 4'd10}, // R10 wrap
    '{2'd0, 1'b0, 1'b0, 1'b0, 2'b00, 4'd0, 18'h0,     1'b1, 18'h2A5A5, 4'd12}, // R12 hold
    '{2'd1, 1'b0, 1'b1, 1'b0, 2'b00, 4'd2, 18'h11111, 1'b1, 18'h00F0F, 4'd3},  // R3 first read
    '{2'd0, 1'b0, 1'b0, 1'b1, 2'b01, 4'd0, 18'h3FFFF, 1'b0, 18'h0,     4'd6},  // R6 lane 0
    '{2'd2, 1'b0, 1'b0, 1'b0, 2'b00, 4'd2, 18'h0,     1'b1, 18'h10FFF, 4'd3},  // R3 R6
    '{2'd2, 1'b0, 1'b0, 1'b1, 2'b10, 4'd3, 18'h0,     1'b0, 18'h0,     4'd6},  // R6 lane 1
    '{2'd2, 1'b0, 1'b1, 1'b1, 2'b00, 4'd1, 18'h2468A, 1'b0, 18'h0,     4'd5},  // R5 override
    '{2'd2, 1'b0, 1'b0, 1'b0, 2'b11, 4'd0, 18'h0,     1'b1, 18'h2A5A5, 4'd4},  // R4 R6 no enable
    '{2'd2, 1'b0, 1'b0, 1'b0, 2'b00, 4'd3, 18'h0,     1'b1, 18'h100C3, 4'd6},
    '{2'd2, 1'b0, 1'b0, 1'b0, 2'b00, 4'd1, 18'h0,     1'b1, 18'h2468A, 4'd5}
  };

  task automatic check(input string tag, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input int st, input bit adv, input bit gw, input bit bwe,
                       input logic [1:0] ls, input logic [3:0] a, input logic [17:0] d);
    cpu_start_n = (st != 1);
    ctl_start_n = (st != 2);
    adv_n       = !adv;
    all_wr_n    = !gw;
    lane_wr_n   = !bwe;
    lane_sel_n  = ~ls;
    addr        = a;
    wdata       = d;
  endtask

  task automatic cycle(input int st, input bit adv, input bit gw, input bit bwe,
                       input logic [1:0] ls, input logic [3:0] a, input logic [17:0] d);
    @(negedge clk);
    drive(st, adv, gw, bwe, ls, a, d);
    @(posedge clk);
    #1;
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_n = 1'b0;
    sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0;
    lin_order = 1'b1; out_en_n = 1'b0; sleep = 1'b0;
    drive(0, 0, 0, 0, 2'b00, 4'd0, 18'h0);
    repeat (3) @(posedge clk);
    #1;
    check("R13 bus_drive after reset", {17'b0, bus_drive}, 18'h0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 17; i++) begin
      cycle(TBL[i].st, TBL[i].adv, TBL[i].gw, TBL[i].bwe, TBL[i].ls, TBL[i].ad, TBL[i].wd);
      if (TBL[i].chk) begin
        checks++;
        if (rdata !== TBL[i].ex) begin
          failures++;
          $display("FAIL R%0d table row %0d actual=%h expected=%h", TBL[i].rq, i, rdata, TBL[i].ex);
        end
      end
    end

    // R11 interleaved order from base 1: 1,0,3,2
    lin_order = 1'b0;
    cycle(2, 0, 0, 0, 2'b00, 4'd1, 18'h0);
    check("R11 interleave start", rdata, 18'h2468A);
    cycle(0, 1, 0, 0, 2'b00, 4'd0, 18'h0);
    check("R11 interleave k=1", rdata, 18'h2A5A5);
    cycle(0, 1, 0, 0, 2'b00, 4'd0, 18'h0);
    check("R11 interleave k=2", rdata, 18'h100C3);
    cycle(0, 1, 0, 0, 2'b00, 4'd0, 18'h0);
    check("R11 interleave k=3", rdata, 18'h10FFF);
    lin_order = 1'b1;

    // R10 burst write from 5 wraps to 4, upper bits kept
    cycle(2, 0, 1, 0, 2'b00, 4'd5, 18'h0AAAA);
    cycle(0, 1, 1, 0, 2'b00, 4'd0, 18'h0BBBB);
    cycle(0, 1, 1, 0, 2'b00, 4'd0, 18'h0CCCC);
    cycle(0, 1, 1, 0, 2'b00, 4'd0, 18'h0DDDD);
    cycle(2, 0, 0, 0, 2'b00, 4'd4, 18'h0);
    check("R10 burst write wrap to 4", rdata, 18'h0DDDD);
    cycle(2, 0, 0, 0, 2'b00, 4'd6, 18'h0);
    check("R10 burst write addr 6", rdata, 18'h0BBBB);

    // R1 deselect via sel_c_n, then via sel_b; strobes carry global writes
    sel_c_n = 1'b1;
    cycle(2, 0, 1, 0, 2'b00, 4'd0, 18'h0);
    sel_c_n = 1'b0;
    check("R1 bus idle after deselect", {17'b0, bus_drive}, 18'h0);
    sel_b = 1'b0;
    cycle(2, 0, 1, 0, 2'b00, 4'd1, 18'h0);
    sel_b = 1'b1;
    // R2 gated processor strobe with no burst open
    sel_a_n = 1'b1;
    cycle(1, 0, 1, 0, 2'b00, 4'd3, 18'h0);
    sel_a_n = 1'b0;
    check("R2 gated strobe leaves bus idle", {17'b0, bus_drive}, 18'h0);
    cycle(2, 0, 0, 0, 2'b00, 4'd0, 18'h0);
    check("R1 addr 0 unwritten when deselected", rdata, 18'h2A5A5);
    cycle(2, 0, 0, 0, 2'b00, 4'd1, 18'h0);
    check("R1 addr 1 unwritten when deselected", rdata, 18'h2468A);
    cycle(2, 0, 0, 0, 2'b00, 4'd3, 18'h0);
    check("R2 addr 3 unwritten by gated strobe", rdata, 18'h100C3);

    // R8 bus drive conditions after a read
    @(negedge clk);
    drive(0, 0, 0, 0, 2'b00, 4'd0, 18'h0);
    #1;
    check("R8 drive after read", {17'b0, bus_drive}, 18'h1);
    out_en_n = 1'b1;
    #1;
    check("R8 no drive with out_en_n high", {17'b0, bus_drive}, 18'h0);
    out_en_n = 1'b0;
    all_wr_n = 1'b0;
    #1;
    check("R8 no drive on write detect", {17'b0, bus_drive}, 18'h0);
    all_wr_n = 1'b1;

    // R9 sleep: strobe to addr 3 with global write is ignored
    cycle(2, 0, 0, 0, 2'b00, 4'd1, 18'h0);
    check("R7 read before sleep", rdata, 18'h2468A);
    @(negedge clk);
    sleep = 1'b1;
    drive(2, 0, 1, 0, 2'b00, 4'd3, 18'h0);
    #1;
    check("R9 no drive in sleep", {17'b0, bus_drive}, 18'h0);
    @(posedge clk);
    @(posedge clk);
    #1;
    check("R9 rdata frozen in sleep", rdata, 18'h2468A);
    @(negedge clk);
    drive(0, 0, 0, 0, 2'b00, 4'd0, 18'h0);
    @(negedge clk);
    sleep = 1'b0;
    @(posedge clk);
    #1;
    check("R9 R12 burst address kept across sleep", rdata, 18'h2468A);
    cycle(2, 0, 0, 0, 2'b00, 4'd3, 18'h0);
    check("R9 memory kept across sleep", rdata, 18'h100C3);

    summary();
  end
endmodule